// File: doc/BRIEF.md
# Countdown timer channel

A single 32-bit down-counting timer channel on a small register bus. Software stores a reload interval and a current count, then chooses a run mode through the control register. The count is decremented once per prescaled tick. `tick_i` stands in for the already selected timer clock, and the prescaler divides it by a power of two. When the count steps from 1 to 0, a pending flag is set. The interrupt line is the pending flag gated by the interrupt enable.

The run mode is held in a three-state machine. The states are STOPPED, ONESHOT and PERIODIC. A control write moves the machine to the state that its enable and autoreload bits select, from any state. In ONESHOT, the expiry transition returns the machine to STOPPED, and the count is left at 0. In PERIODIC, the expiry transition stays in PERIODIC and the count is loaded from the interval register. STOPPED has no transition of its own. Every register read returns the live value.

Top module: `cdt_channel`

## Requirements
- R1: After reset all five registers read 0, `irq_o` is low and the channel is stopped.
- R2: The register offsets are: interrupt enable 0x00 (bit 0), pending status 0x04 (bit 0), control 0x10, interval 0x14 and current count 0x18. In the control register, bit 0 is run enable and bit 1 is autoreload. Bit 2 is the clock-source select, which is stored and read back only. Bits 6:4 hold the prescale exponent. While the channel is stopped, bit 1 reads 0. Unmapped offsets read 0.
- R3: The count decrements by exactly one per prescaled tick while enabled. Ticks have no effect while the channel is stopped.
- R4: A prescale exponent N passes one step for every 2^N ticks. The prescale count restarts from zero whenever the channel is stopped.
- R5: A step from count 1 sets status bit 0 at the same clock edge that updates the count.
- R6: In periodic mode an expiry loads the interval value and the channel keeps running.
- R7: In one-shot mode an expiry leaves the count at 0 and clears the enable bit.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R9: `irq_o` is high exactly when status bit 0 and enable bit 0 are both 1.
- R10: A write to the current count takes priority over a step in the same cycle. The first timeout is then counted from the written value, independent of the interval.
- R11: A step while the count is 0 wraps it to all ones and does not raise an expiry.
- R12: A control write in the same cycle as a one-shot expiry sets the new mode. The expiry still sets the status bit and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer clock pulse (one cycle per source tick) |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Live read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The channel is driven three ways. The first is sparse ticks with the prescaler at divide-by-1, which separates stepping from stopped behaviour. The second is bursts of ticks at larger exponents, which show whether the divider restarts when the channel is stopped. The third is bus writes placed on the exact cycle of a step or an expiry, which exposes the priority between a write and the counter. A final random run in periodic mode, with random ticks and status clears, is compared against the reference every cycle. It catches errors in reload timing and in pending-flag handling that the fixed patterns could miss.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        CH_STOPPED  = 2'd0,
        CH_ONESHOT  = 2'd1,
        CH_PERIODIC = 2'd3
    } ch_state_e;

    localparam int OFS_IEN   = 'h00;
    localparam int OFS_STA   = 'h04;
    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_INTV  = 'h14;
    localparam int OFS_CUR   = 'h18;

    localparam int CTL_EN      = 0;
    localparam int CTL_AUTO    = 1;
    localparam int CTL_SRC     = 2;
    localparam int CTL_PSC_LSB = 4;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             step_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    // limit = 2^N - 1, built bit by bit
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            lim[i] = (i < int'(psc_i));
        end
    end

    assign wrap   = (cnt_q >= lim);
    assign step_o = run_i && tick_i && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              wr_ctrl_i,
    input  logic              ctrl_en_i,
    input  logic              ctrl_auto_i,
    input  logic              wr_cur_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] interval_i,
    output ch_state_e         state_o,
    output logic [DATA_W-1:0] cur_o,
    output logic              expire_o,
    output logic              run_o
);
    timeunit 1ns;
    timeprecision 100ps;

    ch_state_e         state_q, state_d;
    logic [DATA_W-1:0] cur_q, cur_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STOPPED;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // outputs and counter datapath
    always_comb begin
        run_o    = (state_q != CH_STOPPED);
        expire_o = step_i && !wr_cur_i && (cur_q == DATA_W'(1));
        cur_d    = cur_q;
        if (wr_cur_i) begin
            cur_d = wdata_i;
        end else if (step_i) begin
            if (expire_o) begin
                cur_d = (state_q == CH_PERIODIC) ? interval_i : '0;
            end else begin
                cur_d = cur_q - 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (wr_ctrl_i) begin
            if (!ctrl_en_i)       state_d = CH_STOPPED;
            else if (ctrl_auto_i) state_d = CH_PERIODIC;
            else                  state_d = CH_ONESHOT;
        end else begin
            unique case (state_q)
                CH_STOPPED:  state_d = CH_STOPPED;
                CH_ONESHOT:  if (expire_o) state_d = CH_STOPPED;
                CH_PERIODIC: state_d = CH_PERIODIC;
                default:     state_d = CH_STOPPED;
            endcase
        end
    end

    assign state_o = state_q;
    assign cur_o   = cur_q;

    a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ONESHOT && expire_o && !wr_ctrl_i) |=> (state_q == CH_STOPPED && cur_q == '0));
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PERIODIC && expire_o) |=> (cur_q == $past(interval_i)));
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_cur_i && cur_q > DATA_W'(1)) |=> (cur_q == $past(cur_q) - 1'b1));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !wr_cur_i) |=> $stable(cur_q));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  ch_state_e         state_i,
    input  logic [DATA_W-1:0] cur_i,
    input  logic              expire_i,
    output logic              wr_ctrl_o,
    output logic              wr_cur_o,
    output logic [DATA_W-1:0] interval_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic hit_ien, hit_sta, hit_ctrl, hit_intv, hit_cur;
    logic ien_q, sta_q, src_q;
    logic [PSC_W-1:0]  psc_q;
    logic [DATA_W-1:0] intv_q;
    logic [DATA_W-1:0] ctrl_view;

    assign hit_ien  = (bus_addr == ADDR_W'(OFS_IEN));
    assign hit_sta  = (bus_addr == ADDR_W'(OFS_STA));
    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_intv = (bus_addr == ADDR_W'(OFS_INTV));
    assign hit_cur  = (bus_addr == ADDR_W'(OFS_CUR));

    assign wr_ctrl_o = bus_we && hit_ctrl;
    assign wr_cur_o  = bus_we && hit_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            sta_q  <= 1'b0;
            src_q  <= 1'b0;
            psc_q  <= '0;
            intv_q <= '0;
        end else begin
            if (bus_we && hit_ien)  ien_q  <= bus_wdata[0];
            if (bus_we && hit_intv) intv_q <= bus_wdata;
            if (wr_ctrl_o) begin
                src_q <= bus_wdata[CTL_SRC];
                psc_q <= bus_wdata[CTL_PSC_LSB +: PSC_W];
            end
            sta_q <= (sta_q && !(bus_we && hit_sta && bus_wdata[0])) || expire_i;
        end
    end

    always_comb begin
        ctrl_view                           = '0;
        ctrl_view[CTL_EN]                   = (state_i != CH_STOPPED);
        ctrl_view[CTL_AUTO]                 = (state_i == CH_PERIODIC);
        ctrl_view[CTL_SRC]                  = src_q;
        ctrl_view[CTL_PSC_LSB +: PSC_W]     = psc_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ien)       bus_rdata[0] = ien_q;
        else if (hit_sta)  bus_rdata[0] = sta_q;
        else if (hit_ctrl) bus_rdata    = ctrl_view;
        else if (hit_intv) bus_rdata    = intv_q;
        else if (hit_cur)  bus_rdata    = cur_i;
    end

    assign interval_o = intv_q;
    assign psc_o      = psc_q;
    assign irq_o      = sta_q && ien_q;

    a_r5_pending: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> sta_q);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_sta && bus_wdata[0] && !expire_i) |=> !sta_q);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_we && hit_sta) && !expire_i) |=> $stable(sta_q));
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    timeunit 1ns;
    timeprecision 100ps;

    ch_state_e         state;
    logic [DATA_W-1:0] cur, interval;
    logic [PSC_W-1:0]  psc;
    logic              expire, run, step, wr_ctrl, wr_cur;

    cdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .state_i(state), .cur_i(cur), .expire_i(expire),
        .wr_ctrl_o(wr_ctrl), .wr_cur_o(wr_cur), .interval_o(interval),
        .psc_o(psc), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    cdt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i),
        .psc_i(psc), .step_o(step)
    );

    cdt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .step_i(step), .wr_ctrl_i(wr_ctrl),
        .ctrl_en_i(bus_wdata[CTL_EN]), .ctrl_auto_i(bus_wdata[CTL_AUTO]),
        .wr_cur_i(wr_cur), .wdata_i(bus_wdata), .interval_i(interval),
        .state_o(state), .cur_o(cur), .expire_o(expire), .run_o(run)
    );

    // R9: interrupt line follows pending flag and enable
    a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_addr != ADDR_W'(OFS_STA) || bus_rdata[0]));
endmodule

// File: tb/test_cdt_channel.sv
module test_cdt_channel;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [7:0] A_IEN = 8'h00, A_STA = 8'h04, A_CTRL = 8'h10,
                           A_INTV = 8'h14, A_CUR = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc_n = 0;
    string cur_req = "R1";

    // reference model state
    logic        m_ien, m_sta, m_en, m_auto, m_src;
    logic [2:0]  m_psc;
    logic [31:0] m_int, m_cur;
    int          m_pc;

    cdt_channel i_cdt_channel (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            A_IEN:  return {31'd0, m_ien};
            A_STA:  return {31'd0, m_sta};
            A_CTRL: return {25'd0, m_psc, 1'b0, m_src, m_auto, m_en};
            A_INTV: return m_int;
            A_CUR:  return m_cur;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ien = 0; m_sta = 0; m_en = 0; m_auto = 0; m_src = 0;
            m_psc = 0; m_int = 0; m_cur = 0; m_pc = 0;
        end else begin
            logic s, ex;
            logic [31:0] ncur;
            logic nen, nauto;
            s = 0; ex = 0;
            ncur = m_cur; nen = m_en; nauto = m_auto;
            if (!m_en) m_pc = 0;
            else if (tick) begin
                if (m_pc + 1 >= (1 << m_psc)) begin s = 1; m_pc = 0; end
                else m_pc = m_pc + 1;
            end
            if (we && addr == A_CUR) ncur = wdata;
            else if (s) begin
                if (m_cur == 1) begin
                    ex = 1;
                    if (m_auto) ncur = m_int;
                    else begin ncur = 0; nen = 0; nauto = 0; end
                end else ncur = m_cur - 1;
            end
            if (we && addr == A_CTRL) begin
                nen = wdata[0]; nauto = wdata[0] & wdata[1];
                m_src = wdata[2]; m_psc = wdata[6:4];
            end
            if (we && addr == A_STA && wdata[0]) m_sta = 0;
            if (ex) m_sta = 1;
            if (we && addr == A_IEN) m_ien = wdata[0];
            if (we && addr == A_INTV) m_int = wdata;
            m_cur = ncur; m_en = nen; m_auto = nauto;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp += 2;
            if (rdata !== m_read(addr)) begin
                n_bad++;
                $display("FAIL %s: reg %h got %h expected %h", cur_req, addr, rdata, m_read(addr));
            end
            if (irq !== (m_sta & m_ien)) begin
                n_bad++;
                $display("FAIL %s: irq got %b expected %b", cur_req, irq, m_sta & m_ien);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 50000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc_n);
            summary();
            $finish;
        end
    end

    task automatic drive(input logic t, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #0.2;
        tick = t; we = w; addr = a; wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(0, 1, a, d);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) drive(1, 0, A_CUR, 0);
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #0.2;
        tick = 0; we = 0; addr = a; wdata = 0;
        #0.3;
        n_cmp++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: reg %h got %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk); #0.5;
        n_cmp++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        chk(A_IEN, 0, "R1"); chk(A_STA, 0, "R1"); chk(A_CTRL, 0, "R1");
        chk(A_INTV, 0, "R1"); chk(A_CUR, 0, "R1"); chk_irq(0, "R1");

        cur_req = "R2";
        wr(A_IEN, 1); wr(A_INTV, 32'hDEADBEEF); wr(A_CUR, 32'h12345678);
        wr(A_CTRL, 32'h56);
        chk(A_CTRL, 32'h54, "R2"); chk(A_INTV, 32'hDEADBEEF, "R2");
        chk(A_CUR, 32'h12345678, "R2"); chk(A_IEN, 1, "R2"); chk(8'h08, 0, "R2");

        cur_req = "R3";
        wr(A_CTRL, 0); wr(A_CUR, 10); tk(3);
        chk(A_CUR, 10, "R3");
        wr(A_CTRL, 1); tk(3);
        chk(A_CUR, 7, "R3"); chk(A_CUR, 7, "R3");

        cur_req = "R4";
        wr(A_CTRL, 32'h21); wr(A_CUR, 100); tk(8);
        chk(A_CUR, 98, "R4");
        tk(3); wr(A_CTRL, 0); wr(A_CTRL, 32'h21); tk(3);
        chk(A_CUR, 98, "R4");
        tk(1);
        chk(A_CUR, 97, "R4");

        cur_req = "R7";
        wr(A_CTRL, 0); wr(A_STA, 1); wr(A_CUR, 3); wr(A_CTRL, 1); tk(2);
        chk(A_CUR, 1, "R5"); chk(A_STA, 0, "R5");
        tk(1);
        chk(A_STA, 1, "R5"); chk(A_CUR, 0, "R7"); chk(A_CTRL, 0, "R7"); chk_irq(1, "R9");
        tk(2);
        chk(A_CUR, 0, "R3");

        cur_req = "R8";
        wr(A_STA, 0); chk(A_STA, 1, "R8");
        wr(A_STA, 1); chk(A_STA, 0, "R8"); chk_irq(0, "R9");

        cur_req = "R6";
        wr(A_INTV, 4); wr(A_CUR, 2); wr(A_CTRL, 3); tk(2);
        chk(A_CUR, 4, "R6"); chk(A_STA, 1, "R6"); chk(A_CTRL, 3, "R6");
        wr(A_STA, 1); tk(4);
        chk(A_CUR, 4, "R6"); chk(A_STA, 1, "R6");

        cur_req = "R8";
        wr(A_STA, 1); tk(3);
        chk(A_CUR, 1, "R8");
        drive(1, 1, A_STA, 1);
        chk(A_STA, 1, "R8"); chk(A_CUR, 4, "R6");

        cur_req = "R9";
        wr(A_IEN, 0); chk_irq(0, "R9");
        wr(A_IEN, 1); chk_irq(1, "R9");

        cur_req = "R10";
        drive(1, 1, A_CUR, 20);
        chk(A_CUR, 20, "R10");
        wr(A_STA, 1); tk(19);
        chk(A_CUR, 1, "R10"); chk(A_STA, 0, "R10");
        tk(1);
        chk(A_CUR, 4, "R10"); chk(A_STA, 1, "R10");

        cur_req = "R11";
        wr(A_CTRL, 0); wr(A_STA, 1); wr(A_CUR, 0); wr(A_CTRL, 1); tk(1);
        chk(A_CUR, 32'hFFFFFFFF, "R11"); chk(A_STA, 0, "R11"); chk(A_CTRL, 1, "R11");

        cur_req = "R12";
        wr(A_CUR, 1);
        drive(1, 1, A_CTRL, 3);
        chk(A_CTRL, 3, "R12"); chk(A_STA, 1, "R12"); chk(A_CUR, 0, "R12");
        wr(A_CTRL, 0);

        cur_req = "R6";
        wr(A_STA, 1); wr(A_INTV, 5); wr(A_CUR, 3); wr(A_CTRL, 32'h13);
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0) drive(0, 1, A_STA, 1);
            else if (r == 1) drive($urandom_range(0, 1), 1, A_CTRL, {25'd0, 3'($urandom_range(0, 2)), 4'b0011});
            else drive($urandom_range(0, 1), 0, (r < 8) ? A_CUR : A_STA, 0);
        end
        wr(A_CTRL, 0);
        chk(A_CTRL, 0, "R3");

        summary();
        $finish;
    end
endmodule